// File: doc/BRIEF.md
# Multi-Format Two-Channel Audio Serial Receiver

This block takes a two-channel serial audio stream made of a bit clock, a word (left/right) clock and a data line. It delivers each left/right pair as two signed 24-bit words together with a one-cycle strobe. All three serial lines are sampled in the system clock domain. A short synchronizer and a rising-edge detector on the bit clock decide when a data bit and the word-clock level are taken. The bit clock therefore has to be several times slower than the system clock.

A 3-bit format code picks how a sample sits inside its half-frame. The choices are right-aligned (LSB-justified) words of 16, 20 or 24 bits, a left-aligned 24-bit word, and the I2S framing with its one-bit delay. Samples are two's complement and arrive MSB first. Right-aligned words are sign-extended to 24 bits. A left-aligned word that is shorter than 24 bits comes out with zeros in its missing low bits.

Top module: `aud_serial_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `left_sample` and `right_sample` are zero and `pair_valid` is low until the first pair is delivered.
- R2: A data bit and the word-clock level are taken only at a rising edge of the bit clock. Data is MSB first, two's complement. A half-frame ends at the first rising edge at which the word clock has a new level.
- R3: Format code 0 delivers the last 16 bits of each half-frame, sign-extended from bit 15, and ignores all earlier bits. It works with 16 bit clocks per half-frame (32fs).
- R4: Format code 1 delivers the last 20 bits of each half-frame, sign-extended from bit 19, and ignores all earlier bits. It works with 20 bit clocks per half-frame (40fs).
- R5: Format code 4 delivers the last 24 bits of each half-frame and ignores all earlier bits. It works with 24 bit clocks per half-frame (48fs).
- R6: Format code 2 takes the first 24 bits after the word-clock change (MSB first) and ignores later bits. If a half-frame holds fewer than 24 bits, the missing low bits are zero.
- R7: Format code 3 (I2S) carries left while the word clock is low and right while it is high. The bit at the first edge after the change is skipped, and the next 24 bits form the word, MSB first.
- R8: Format codes 5, 6 and 7 behave exactly like code 2.
- R9: `pair_valid` is high for exactly one system clock once a right-channel word completes after a left word. `left_sample` and `right_sample` change only in that cycle and hold their values otherwise.
- R10: After reset, the half-frame in progress is discarded. A right word with no completed left word before it produces no pulse.
- R11: In formats 0, 1, 2, 4 and 5 to 7, left is carried while the word clock is high. The left word of a pair precedes its right word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_sel | input | 3 | Framing code (0: 16-bit right-aligned, 1: 20-bit right-aligned, 2: 24-bit left-aligned, 3: I2S, 4: 24-bit right-aligned, 5-7: as 2) |
| bclk_in | input | 1 | Serial bit clock, asynchronous to clk |
| wclk_in | input | 1 | Word clock selecting the channel |
| sdata_in | input | 1 | Serial data |
| left_sample | output | 24 | Last delivered left word, signed |
| right_sample | output | 24 | Last delivered right word, signed |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
Some properties are checked on every cycle by the assertions:
- the strobe lasts a single clock and always follows a detected bit-clock edge;
- the sample outputs stay frozen between strobes;
- in the 16- and 20-bit right-aligned codes, the delivered words are properly sign-extended.

Other behaviour can only be shown by the directed scenarios, which drive framed streams and compare the delivered pairs against words the bench computes itself. These scenarios cover:
- which bits land in the word in each framing, including I2S's skipped first slot and the channel polarity;
- that junk bits outside the word are ignored;
- the zero fill of short left-aligned words;
- the aliasing of codes 5 to 7;
- the discarding of a partial half-frame after reset.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int SAMPLE_W = 24;

  typedef enum logic [2:0] {
    FMT_LSB16 = 3'd0,
    FMT_LSB20 = 3'd1,
    FMT_MSB24 = 3'd2,
    FMT_I2S   = 3'd3,
    FMT_LSB24 = 3'd4
  } fmt_e;

  // Unused codes fold onto the left-aligned 24-bit framing.
  function automatic fmt_e norm_fmt(input logic [2:0] code);
    case (code)
      3'd0:    return FMT_LSB16;
      3'd1:    return FMT_LSB20;
      3'd3:    return FMT_I2S;
      3'd4:    return FMT_LSB24;
      default: return FMT_MSB24;
    endcase
  endfunction

  function automatic logic is_right_aligned(input fmt_e f);
    return (f == FMT_LSB16) || (f == FMT_LSB20) || (f == FMT_LSB24);
  endfunction

  // Word-clock level that marks the left channel.
  function automatic logic left_level(input fmt_e f);
    return (f == FMT_I2S) ? 1'b0 : 1'b1;
  endfunction

  // Take the tail of the shift history and sign-extend it to full width.
  function automatic logic [SAMPLE_W-1:0] tail_word(input logic [SAMPLE_W-1:0] hist,
                                                    input fmt_e f);
    case (f)
      FMT_LSB16: return {{(SAMPLE_W-16){hist[15]}}, hist[15:0]};
      FMT_LSB20: return {{(SAMPLE_W-20){hist[19]}}, hist[19:0]};
      default:   return hist;
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_sync_edge.sv
module aud_rx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic wclk_in,
  input  logic sdata_in,
  output logic bclk_rise,
  output logic lr_bit,
  output logic sd_bit
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            bclk_prev;

  assign raw = {bclk_in, wclk_in, sdata_in};

  generate
    for (genvar s = 0; s < NSIG; s++) begin : g_sync
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], raw[s]};
      end
      assign synced[s] = pipe[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev <= 1'b0;
    else        bclk_prev <= synced[2];
  end

  assign bclk_rise = synced[2] & ~bclk_prev;
  assign lr_bit    = synced[1];
  assign sd_bit    = synced[0];

endmodule

// File: rtl/aud_rx_capture.sv
module aud_rx_capture
  import aud_rx_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_rise,
  input  logic         lr_bit,
  input  logic         sd_bit,
  input  fmt_e         fmt,
  output logic         word_done,
  output logic         word_is_left,
  output logic [W-1:0] word_data
);
  localparam int POS_W = $clog2(W + 2);
  localparam int IDX_W = $clog2(W);
  localparam logic [POS_W-1:0] POS_END  = POS_W'(W);
  localparam logic [POS_W-1:0] POS_IDLE = POS_W'(W + 1);

  logic             seen, started, prev_lr;
  logic [W-1:0]     hist, acc, acc_next;
  logic [POS_W-1:0] pos, cur_pos, pos_next, idx;
  logic             lr_change;

  assign lr_change = seen && (lr_bit != prev_lr);

  always_comb begin
    cur_pos  = lr_change ? ((fmt == FMT_I2S) ? '0 : POS_W'(1)) : pos;
    acc_next = lr_change ? '0 : acc;
    idx      = POS_END - cur_pos;
    if (cur_pos != '0 && cur_pos <= POS_END)
      acc_next[idx[IDX_W-1:0]] = sd_bit;
    pos_next = (cur_pos > POS_END) ? cur_pos : cur_pos + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen         <= 1'b0;
      started      <= 1'b0;
      prev_lr      <= 1'b0;
      hist         <= '0;
      acc          <= '0;
      pos          <= POS_IDLE;
      word_done    <= 1'b0;
      word_is_left <= 1'b0;
      word_data    <= '0;
    end else begin
      word_done <= bclk_rise && lr_change && started;
      if (bclk_rise) begin
        seen    <= 1'b1;
        prev_lr <= lr_bit;
        hist    <= {hist[W-2:0], sd_bit};
        acc     <= acc_next;
        pos     <= pos_next;
        started <= started | lr_change;
        if (lr_change) begin
          word_data    <= is_right_aligned(fmt) ? tail_word(hist, fmt) : acc;
          word_is_left <= (prev_lr == left_level(fmt));
        end
      end
    end
  end

endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_done,
  input  logic         word_is_left,
  input  logic [W-1:0] word_data,
  output logic [W-1:0] left_sample,
  output logic [W-1:0] right_sample,
  output logic         pair_valid
);
  logic [W-1:0] left_hold;
  logic         have_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold    <= '0;
      have_left    <= 1'b0;
      left_sample  <= '0;
      right_sample <= '0;
      pair_valid   <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (word_done) begin
        if (word_is_left) begin
          left_hold <= word_data;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_sample  <= left_hold;
          right_sample <= word_data;
          pair_valid   <= 1'b1;
          have_left    <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt_sel,
  input  logic                bclk_in,
  input  logic                wclk_in,
  input  logic                sdata_in,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                pair_valid
);
  logic                bclk_rise, lr_bit, sd_bit;
  logic                word_done, word_is_left;
  logic [SAMPLE_W-1:0] word_data;
  fmt_e                fmt_n;

  assign fmt_n = norm_fmt(fmt_sel);

  aud_rx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .wclk_in(wclk_in),
    .sdata_in(sdata_in), .bclk_rise(bclk_rise), .lr_bit(lr_bit), .sd_bit(sd_bit)
  );

  aud_rx_capture #(.W(SAMPLE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .lr_bit(lr_bit),
    .sd_bit(sd_bit), .fmt(fmt_n), .word_done(word_done),
    .word_is_left(word_is_left), .word_data(word_data)
  );

  aud_rx_pair #(.W(SAMPLE_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_is_left(word_is_left),
    .word_data(word_data), .left_sample(left_sample),
    .right_sample(right_sample), .pair_valid(pair_valid)
  );

endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  fmt_sel,
  input logic        bclk_rise,
  input logic        pair_valid,
  input logic [23:0] left_sample,
  input logic [23:0] right_sample
);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid); // R9

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(left_sample) && $stable(right_sample))); // R9

  AST_STROBE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(bclk_rise, 2)); // R2

  AST_SEXT_16: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && fmt_sel == 3'd0 && $past(fmt_sel, 2) == 3'd0) |->
      ((left_sample[23:15] == '0 || left_sample[23:15] == '1) &&
       (right_sample[23:15] == '0 || right_sample[23:15] == '1))); // R3

  AST_SEXT_20: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && fmt_sel == 3'd1 && $past(fmt_sel, 2) == 3'd1) |->
      ((left_sample[23:19] == '0 || left_sample[23:19] == '1) &&
       (right_sample[23:19] == '0 || right_sample[23:19] == '1))); // R4

endmodule

bind aud_serial_rx aud_serial_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bclk_rise(bclk_rise),
  .pair_valid(pair_valid), .left_sample(left_sample), .right_sample(right_sample)
);

// File: tb/tb_aud_serial_rx.sv
module tb_aud_serial_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = 3'd2;
  logic        bclk = 1'b0, wclk = 1'b1, sdat = 1'b0;
  logic [23:0] left_sample, right_sample;
  logic        pair_valid;

  int checks = 0, errors = 0;
  int ngot = 0, dbl = 0;
  logic prev_pv = 1'b0;
  logic [23:0] got_l [0:7];
  logic [23:0] got_r [0:7];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bclk_in(bclk), .wclk_in(wclk),
    .sdata_in(sdat), .left_sample(left_sample), .right_sample(right_sample),
    .pair_valid(pair_valid)
  );

  always @(negedge clk) begin
    if (pair_valid && prev_pv) dbl++;
    prev_pv = pair_valid;
    if (pair_valid && ngot < 8) begin
      got_l[ngot] = left_sample;
      got_r[ngot] = right_sample;
      ngot++;
    end
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nf(input int f);
    return (f >= 5) ? 2 : f;
  endfunction

  function automatic logic [23:0] exp_word(input int f, input int b, input logic [23:0] w);
    logic [23:0] r;
    case (nf(f))
      0: r = {{8{w[15]}}, w[15:0]};
      1: r = {{4{w[19]}}, w[19:0]};
      4: r = w;
      2: begin
        r = w;
        for (int j = 0; j < 24; j++) if (23 - j >= b) r[j] = 1'b0;
      end
      default: begin
        r = w;
        for (int j = 0; j < 24; j++) if (24 - j > b - 1) r[j] = 1'b0;
      end
    endcase
    return r;
  endfunction

  function automatic logic tb_bit(input int f, input int b, input logic [23:0] w, input int i);
    int n;
    logic junk;
    junk = (i % 2 == 0);
    case (nf(f))
      0, 1, 4: begin
        n = (nf(f) == 0) ? 16 : (nf(f) == 1) ? 20 : 24;
        return (i >= b - n) ? w[b-1-i] : junk;
      end
      2:       return (i < 24) ? w[23-i] : junk;
      default: return (i >= 1 && i <= 24) ? w[24-i] : junk;
    endcase
  endfunction

  task automatic send_bit(input logic lr, input logic d);
    @(negedge clk);
    bclk = 1'b0; wclk = lr; sdat = d;
    repeat (HB) @(negedge clk);
    bclk = 1'b1;
    repeat (HB - 1) @(negedge clk);
  endtask

  task automatic send_half(input int f, input int b, input logic lr, input logic [23:0] w);
    for (int i = 0; i < b; i++) send_bit(lr, tb_bit(f, b, w, i));
  endtask

  task automatic start(input int f, input logic idle_lr);
    rst_n = 1'b0; fmt_sel = 3'(f); bclk = 1'b0; wclk = idle_lr; sdat = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    ngot = 0;
  endtask

  // Two frames plus a trailing frame that closes the second pair.
  task automatic run_scn(input string req, input int f, input int b,
                         input logic [23:0] l0, input logic [23:0] r0,
                         input logic [23:0] l1, input logic [23:0] r1);
    logic ll;
    ll = (nf(f) == 3) ? 1'b0 : 1'b1;
    start(f, ~ll);
    send_bit(~ll, 1'b1);
    send_bit(~ll, 1'b0);
    send_half(f, b, ll, l0);  send_half(f, b, ~ll, r0);
    send_half(f, b, ll, l1);  send_half(f, b, ~ll, r1);
    send_half(f, b, ll, 24'h0); send_half(f, b, ~ll, 24'h0);
    repeat (20) @(negedge clk);
    check({req, " pair count"}, 24'(ngot), 24'd2);
    check({req, " left0"},  got_l[0], exp_word(f, b, l0));
    check({req, " right0"}, got_r[0], exp_word(f, b, r0));
    check({req, " left1"},  got_l[1], exp_word(f, b, l1));
    check({req, " right1"}, got_r[1], exp_word(f, b, r1));
    check("R9 left held", left_sample, exp_word(f, b, l1));
    check("R9 right held", right_sample, exp_word(f, b, r1));
  endtask

  task automatic t_reset();
    start(2, 1'b0);
    check("R1 left zero", left_sample, 24'h0);
    check("R1 right zero", right_sample, 24'h0);
    check("R1 strobe low", {23'h0, pair_valid}, 24'h0);
  endtask

  task automatic t_partial();
    start(2, 1'b1);
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
    send_half(2, 32, 1'b0, 24'h777777);
    send_half(2, 32, 1'b1, 24'h13579B);
    send_half(2, 32, 1'b0, 24'hFEDCBA);
    send_half(2, 32, 1'b1, 24'h0);
    send_half(2, 32, 1'b0, 24'h0);
    repeat (20) @(negedge clk);
    check("R10 single pair", 24'(ngot), 24'd1);
    check("R10 left", got_l[0], 24'h13579B);
    check("R10 right", got_r[0], 24'hFEDCBA);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_scn("R3 32fs",       0, 16, 24'h007FFF, 24'h008000, 24'h001234, 24'h00FFFF);
    run_scn("R3 junk",       0, 32, 24'h00A001, 24'h005FFE, 24'h000000, 24'h00C3C3);
    run_scn("R4 40fs",       1, 20, 24'h080001, 24'h07FFFE, 24'h0ABCDE, 24'h012345);
    run_scn("R4 junk",       1, 32, 24'h0FFFFF, 24'h000001, 24'h080000, 24'h055555);
    run_scn("R5 48fs",       4, 24, 24'h800000, 24'h123456, 24'h7FFFFF, 24'hFFFFFF);
    run_scn("R5 junk",       4, 32, 24'hC0FFEE, 24'h000001, 24'h876543, 24'h2AAAAA);
    run_scn("R6 R11 48fs",   2, 24, 24'hA5A5A5, 24'h5A5A5A, 24'h800001, 24'h7FFFFE);
    run_scn("R6 junk",       2, 32, 24'h123456, 24'hFEDCBA, 24'h000001, 24'h800000);
    run_scn("R6 zero fill",  2, 16, 24'hABCDEF, 24'h135791, 24'hFFFFFF, 24'h8000FF);
    run_scn("R7 i2s",        3, 32, 24'hC00001, 24'h3FFFFE, 24'h000001, 24'h800000);
    run_scn("R8 code6",      6, 32, 24'h246801, 24'hDB97FE, 24'h100001, 24'hEFFFFE);
    run_scn("R8 code7",      7, 24, 24'h0F0F0F, 24'hF0F0F0, 24'h333333, 24'hCCCCCC);
    t_partial();
    check("R9 strobe width", 24'(dbl), 24'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule